// File: doc/BRIEF.md
# Interleaved Segment Padder and Distributor

This block is the streaming front end of a parallel tree-style hash. Message bytes enter one per cycle on a valid/ready stream whose last flag marks the final byte. The message length does not need to be known in advance. The block counts bytes as they pass. When it sees the end of the message, it appends standard hash padding, and the padded total becomes a multiple of the group size (segment count times block size) instead of a multiple of a single block.

Bytes are packed into words big-endian. The padded words are dealt round-robin across the segment lanes at word granularity, so lane k receives words k, k+S, k+2S and so on. All lanes therefore receive equal lengths. When every lane holds a complete block, all lanes present their blocks together. Each lane is released through its own ready signal. A marker identifies the group that closes the message. The per-lane compression engines and the final combining hash sit downstream.

Top module: `seg_pad_dealer`

## Requirements
- R1: After reset, every lane valid is low and the input ready is high.
- R2: Message bytes are packed big-endian into words of WORD_BYTES bytes. Word n of a group goes to lane (n mod SEGS) at word slot (n / SEGS). A lane block is output with its byte 0 in the most significant byte of that lane's field, and lane k occupies bits [k*BLK_BYTES*8 +: BLK_BYTES*8] of the data bus.
- R3: The byte after the last message byte is 0x80. It is followed by zero bytes. The final 8 bytes of the last group carry the message length in bits as a 64-bit big-endian value.
- R4: The padded total is the smallest multiple of SEGS*BLK_BYTES that leaves at least 9 bytes after the message. When fewer than 9 bytes remain in the current group, a whole further group of padding follows.
- R5: A message that ends exactly on a group boundary is followed by one complete group that holds only padding, starting with 0x80 at its first byte.
- R6: All lane valids rise in the same cycle. A lane valid stays high until that lane's ready is seen high, and the block data stays unchanged while any lane still waits.
- R7: The input ready is low while any lane valid is high and while padding is being generated. Bytes offered in that time are not taken.
- R8: The final marker is high on the group that carries the length field and low on every earlier group of the message.
- R9: The bit count restarts for each message, so back-to-back messages are padded independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is offered |
| in_ready | output | 1 | Block accepts the offered byte this cycle |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | Offered byte is the last of its message |
| blk_valid | output | SEGS | Per-lane block valid |
| blk_ready | input | SEGS | Per-lane block taken |
| blk_data | output | SEGS*BLK_BYTES*8 | All lane blocks, lane k in bits [k*BLK_BYTES*8 +: BLK_BYTES*8] |
| blk_final | output | 1 | Current group ends the message, qualified by any lane valid |

## Verification
The bench builds the block with two lanes, 8-byte blocks and 4-byte words, which gives a 16-byte group. At that size a few message lengths reach every padding corner: a length that leaves exactly 9 bytes, one that leaves 8 bytes and forces an extra group, and one that ends exactly on a boundary. The bench also runs multi-group messages and back-to-back messages. With two lanes, each word interleaves across a lane boundary in every group. The bench also drives staggered per-lane ready patterns, so lanes drain on different cycles while the input is held off.

// File: rtl/segpad_pkg.sv
package segpad_pkg;
    // Operating mode of the dealer
    typedef enum logic [0:0] {
        MODE_MSG = 1'b0,   // taking message bytes
        MODE_PAD = 1'b1    // generating padding bytes
    } segpad_mode_e;

    localparam logic [7:0] PAD_MARK  = 8'h80;
    localparam int         LEN_BYTES = 8;      // size of the bit-length field
endpackage

// File: rtl/segpad_padbyte.sv
// Produces the padding byte for the current group position.
module segpad_padbyte #(
    parameter int GRP_BYTES = 256
) (
    input  logic [$clog2(GRP_BYTES)-1:0] pos,
    input  logic                         mark_sent,
    input  logic                         len_here,
    input  logic [63:0]                  bit_len,
    output logic [7:0]                   pad_byte
);
    import segpad_pkg::*;

    always_comb begin
        int off;
        off = int'(pos) - (GRP_BYTES - LEN_BYTES);
        if (!mark_sent) begin
            pad_byte = PAD_MARK;
        end else if (len_here && off >= 0) begin
            pad_byte = bit_len[(7 - off) * 8 +: 8];
        end else begin
            pad_byte = 8'h00;
        end
    end
endmodule

// File: rtl/segpad_lanemap.sv
// Pure wiring: scatters the group buffer into per-lane blocks, word-interleaved.
module segpad_lanemap #(
    parameter int SEGS       = 4,
    parameter int BLK_BYTES  = 64,
    parameter int WORD_BYTES = 4
) (
    input  logic [SEGS*BLK_BYTES*8-1:0] grp,
    output logic [SEGS*BLK_BYTES*8-1:0] lanes
);
    localparam int LANE_BITS = BLK_BYTES * 8;

    for (genvar k = 0; k < SEGS; k++) begin : g_lane
        for (genvar j = 0; j < BLK_BYTES; j++) begin : g_byte
            // lane byte j sits in lane word j/W; that word is group word (j/W)*S + k
            localparam int SRC = ((j / WORD_BYTES) * SEGS + k) * WORD_BYTES + (j % WORD_BYTES);
            assign lanes[k*LANE_BITS + (BLK_BYTES-1-j)*8 +: 8] = grp[SRC*8 +: 8];
        end
    end
endmodule

// File: rtl/seg_pad_dealer.sv
module seg_pad_dealer #(
    parameter int SEGS       = 4,   // power of two
    parameter int BLK_BYTES  = 64,
    parameter int WORD_BYTES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [7:0]                  in_data,
    input  logic                        in_last,
    output logic [SEGS-1:0]             blk_valid,
    input  logic [SEGS-1:0]             blk_ready,
    output logic [SEGS*BLK_BYTES*8-1:0] blk_data,
    output logic                        blk_final
);
    import segpad_pkg::*;

    localparam int GRP_BYTES = SEGS * BLK_BYTES;
    localparam int PW        = $clog2(GRP_BYTES);
    localparam int LEN_LIMIT = GRP_BYTES - LEN_BYTES - 1;  // last position the marker may take and still fit the length

    typedef struct packed {
        logic [GRP_BYTES-1:0][7:0] buff;
        logic [PW-1:0]             pos;
        segpad_mode_e              mode;
        logic                      mark_sent;
        logic                      len_here;
        logic [63:0]               bit_len;
        logic [SEGS-1:0]           vld;
        logic                      fin;
    } st_t;

    st_t st_q, st_d;
    logic [7:0] pad_byte;

    segpad_padbyte #(.GRP_BYTES(GRP_BYTES)) u_pad (
        .pos       (st_q.pos),
        .mark_sent (st_q.mark_sent),
        .len_here  (st_q.len_here),
        .bit_len   (st_q.bit_len),
        .pad_byte  (pad_byte)
    );

    segpad_lanemap #(
        .SEGS(SEGS), .BLK_BYTES(BLK_BYTES), .WORD_BYTES(WORD_BYTES)
    ) u_map (
        .grp   (st_q.buff),
        .lanes (blk_data)
    );

    assign in_ready  = (st_q.mode == MODE_MSG) && (st_q.vld == '0);
    assign blk_valid = st_q.vld;
    assign blk_final = st_q.fin;

    always_comb begin
        logic       wr;
        logic [7:0] wbyte;
        st_d  = st_q;
        wr    = 1'b0;
        wbyte = 8'h00;
        st_d.vld = st_q.vld & ~blk_ready;

        if (in_ready && in_valid) begin
            wr           = 1'b1;
            wbyte        = in_data;
            st_d.bit_len = st_q.bit_len + 64'd8;
            if (in_last) begin
                st_d.mode      = MODE_PAD;
                st_d.mark_sent = 1'b0;
                st_d.len_here  = 1'b0;
            end
        end else if (st_q.mode == MODE_PAD && st_q.vld == '0) begin
            wr    = 1'b1;
            wbyte = pad_byte;
            if (!st_q.mark_sent) begin
                st_d.mark_sent = 1'b1;
                st_d.len_here  = (int'(st_q.pos) <= LEN_LIMIT);
            end
        end

        if (wr) begin
            st_d.buff[st_q.pos] = wbyte;
            if (st_q.pos == PW'(GRP_BYTES - 1)) begin
                st_d.pos = '0;
                st_d.vld = '1;
                st_d.fin = (st_q.mode == MODE_PAD) && st_d.len_here;
                if (st_d.fin) begin
                    st_d.mode      = MODE_MSG;
                    st_d.bit_len   = '0;
                    st_d.mark_sent = 1'b0;
                    st_d.len_here  = 1'b0;
                end else if (st_q.mode == MODE_PAD) begin
                    st_d.len_here = 1'b1;   // the following group always has room
                end
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: lanes become valid together
    assert_lanes_together_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|st_q.vld) |-> (&st_q.vld));

    // R6: a waiting lane keeps its valid
    assert_valid_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(blk_valid & ~blk_ready)) |=>
            ((blk_valid & $past(blk_valid & ~blk_ready)) == $past(blk_valid & ~blk_ready)));

    // R6: block data frozen while any lane waits
    assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(blk_valid & ~blk_ready)) |=> $stable(blk_data));

    // R7: no byte taken means the running count does not move
    assert_len_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(in_valid && in_ready) && st_q.mode == MODE_MSG) |=> $stable(st_q.bit_len));

    // R8: a final group can only come out of padding
    assert_final_from_pad_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(|st_q.vld) && st_q.fin) |-> $past(st_q.mode == MODE_PAD));
endmodule

// File: tb/sim_seg_pad_dealer.sv
module sim_seg_pad_dealer;
    localparam int S   = 2;
    localparam int BB  = 8;
    localparam int W   = 4;
    localparam int GB  = S * BB;
    localparam int LB  = BB * 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [7:0]       in_data = 8'h00;
    logic             in_last = 1'b0;
    logic [S-1:0]     blk_valid;
    logic [S-1:0]     blk_ready = '1;
    logic [S*LB-1:0]  blk_data;
    logic             blk_final;

    always #2.5 clk = ~clk;   // 200 MHz

    seg_pad_dealer #(.SEGS(S), .BLK_BYTES(BB), .WORD_BYTES(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .blk_valid(blk_valid),
        .blk_ready(blk_ready), .blk_data(blk_data), .blk_final(blk_final)
    );

    typedef struct {
        logic [S*LB-1:0] data;
        logic            fin;
        string           tag;
    } grp_t;

    grp_t  exp_q[$];
    int    rd_idx[S];
    int    n_chk = 0;
    int    n_bad = 0;
    int    rmode = 0;
    int    cyc = 0;
    bit    done = 0;
    logic  prev_any = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [S*LB-1:0] act, input logic [S*LB-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: computes the expected padded groups, then streams the message
    task automatic send_msg(input int len, input int seed, input string tag);
        byte unsigned b[$];
        logic [63:0]  bits;
        int           ng;
        for (int i = 0; i < len; i++) b.push_back(byte'((i * 37 + seed) & 255));
        bits = 64'(len) * 64'd8;
        b.push_back(8'h80);
        while (b.size() % GB != GB - 8) b.push_back(8'h00);
        for (int i = 0; i < 8; i++) b.push_back(bits[63 - 8*i -: 8]);
        ng = b.size() / GB;
        for (int g = 0; g < ng; g++) begin
            grp_t e;
            e.data = '0;
            for (int p = 0; p < GB; p++) begin
                int k, j;
                k = (p / W) % S;
                j = (p / (W * S)) * W + (p % W);
                e.data[k*LB + (BB-1-j)*8 +: 8] = b[g*GB + p];
            end
            e.fin = (g == ng - 1);
            e.tag = tag;
            exp_q.push_back(e);
        end
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_data  = b[i];
            in_last  = (i == len - 1);
            do @(negedge clk); while (!in_ready);
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b0, "R7 ready low after last", {'0, in_ready}, '0);
    endtask

    // lane ready patterns
    always @(posedge clk) begin
        #1;
        cyc++;
        for (int k = 0; k < S; k++)
            blk_ready[k] = (rmode == 0) ? 1'b1 : (((cyc * (k + 3)) % 5) == 0);
    end

    // monitor: compares each lane as it is taken
    always @(negedge clk) begin
        if (rst_n) begin
            if ((|blk_valid) && !prev_any)
                chk(&blk_valid, "R6 lanes rise together", {'0, blk_valid}, {'0, {S{1'b1}}});
            if (|blk_valid)
                chk(in_ready == 1'b0, "R7 input held while lanes wait", {'0, in_ready}, '0);
            for (int k = 0; k < S; k++) begin
                if (blk_valid[k] && blk_ready[k]) begin
                    if (rd_idx[k] >= exp_q.size()) begin
                        chk(1'b0, "R6 unexpected block", blk_data, '0);
                    end else begin
                        grp_t e;
                        e = exp_q[rd_idx[k]];
                        chk(blk_data[k*LB +: LB] == e.data[k*LB +: LB], e.tag,
                            {'0, blk_data[k*LB +: LB]}, {'0, e.data[k*LB +: LB]});
                        chk(blk_final == e.fin, "R8 final marker", {'0, blk_final}, {'0, e.fin});
                        rd_idx[k]++;
                    end
                end
            end
            prev_any = |blk_valid;
        end
    end

    function automatic bit drained();
        for (int k = 0; k < S; k++) if (rd_idx[k] != exp_q.size()) return 1'b0;
        return 1'b1;
    endfunction

    initial begin
        for (int k = 0; k < S; k++) rd_idx[k] = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(blk_valid == '0, "R1 lanes idle", {'0, blk_valid}, '0);
        chk(in_ready == 1'b1, "R1 input ready", {'0, in_ready}, {'0, 1'b1});
        @(posedge clk); #1;
        send_msg(3,  11, "R2 short message lanes");
        send_msg(7,  20, "R3 marker and length fit");
        send_msg(8,  33, "R4 extra group needed");
        send_msg(16, 44, "R5 boundary message");
        send_msg(5,  55, "R9 back-to-back first");
        send_msg(5,  66, "R9 back-to-back second");
        rmode = 1;
        send_msg(21, 77, "R6 staggered ready");
        send_msg(40, 88, "R7 long message stalled");
        send_msg(9,  99, "R8 two-group final");
        while (!drained()) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(blk_valid == '0, "R6 nothing extra emitted", {'0, blk_valid}, '0);
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule